// File: doc/BRIEF.md
# Serial NOR flash range erase sequencer

This block takes a request to erase a byte range of a serial NOR flash and turns it into the command stream the device needs. It first validates the request against the configured device size and the active erase granule. It then issues one whole-device erase when the range covers the entire device, or one sector erase per granule otherwise. Each erase command is preceded by a busy-wait on the device status byte and by a separate write-enable transaction.

The host side is a single-cycle request strobe with start address and length, plus `busy`, `done` and `error` outputs. Static configuration inputs select the device size, the large-sector size, whether the small 4096-byte erase is used, three- or four-byte addressing, and the status-poll time limit in clock cycles. The flash side is a byte stream to a separate serial shifter. Each byte is offered with `tx_valid`, taken on `tx_ready`, and answered by one `rx_valid` pulse that carries the byte clocked back in. `tx_last` marks the final byte of a chip-select frame. Only one byte is ever in flight.

Top module: `flash_erase_seq`

## Requirements
- R1: A request whose start plus length exceeds `cfg_dev_size` ends with `done` and `error` both high and sends no byte; a range that ends exactly at the device size is accepted.
- R2: A request whose length is not a whole multiple of the erase granule ends with `done` and `error` and sends no byte. The granule is 4096 with small erase, and `cfg_sect_size` otherwise. Both are powers of two.
- R3: A length equal to `cfg_dev_size` produces a single erase frame made of the one byte 0xC7 with no address, instead of per-sector frames.
- R4: With `cfg_small_erase` high the sector erase opcode is 0x20 and the granule is 4096 bytes. With it low the opcode is 0xD8 and the granule is `cfg_sect_size`.
- R5: Before every erase frame the block sends status-read frames of two bytes, 0x05 and then a 0x00 filler marked last. It repeats them while bit 0 of the byte returned for the filler is 1, and all other bits of that byte are ignored.
- R6: A one-byte frame 0x06 is sent directly between the last status read and each erase frame.
- R7: Sector frames target start, start+granule, start+2*granule and so on, and there are exactly length/granule of them.
- R8: A sector frame is the opcode followed by the address, most significant byte first. It carries the low 24 bits in 3 bytes when `cfg_addr4` is low and the full 32 bits in 4 bytes when it is high, and its final byte is marked last.
- R9: If a status read still shows bit 0 set once `cfg_poll_limit` cycles have been spent polling for the current erase, the sequence stops with `done` and `error` and sends no further write-enable or erase.
- R10: `done` is a one-cycle pulse that comes only after the final erase byte has been answered. `error` is high only together with `done`. `busy` is high from the cycle after an accepted request through the `done` cycle.
- R11: A request strobe while `busy` is high is ignored.
- R12: A length of zero ends with `done`, no `error` and no byte sent.
- R13: `tx_valid` with its byte and last flag is held until taken, and no new byte is offered while a taken byte awaits its `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Erase request strobe, taken when idle |
| req_addr | input | AW | Start byte address |
| req_len | input | AW | Length in bytes |
| cfg_dev_size | input | AW | Device size in bytes |
| cfg_sect_size | input | AW | Large-sector erase size in bytes |
| cfg_small_erase | input | 1 | Use 4096-byte erase with opcode 0x20 |
| cfg_addr4 | input | 1 | Send four address bytes instead of three |
| cfg_poll_limit | input | TW | Polling time limit per erase, in cycles |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with done |
| tx_valid | output | 1 | Byte offered to the shifter |
| tx_ready | input | 1 | Shifter takes the offered byte |
| tx_byte | output | 8 | Byte to send |
| tx_last | output | 1 | Byte ends the chip-select frame |
| rx_valid | input | 1 | Shifter has finished the taken byte |
| rx_byte | input | 8 | Byte clocked back from the device |

## Verification
The checker relies on the shifter pulsing `rx_valid` only while a taken byte is outstanding. It also relies on the configuration inputs holding still while `busy` is high. The bench's shifter model answers every taken byte exactly once, one cycle later. It stalls `tx_ready` from a pseudo-random pattern, and the bench changes configuration only between requests. The status byte returned by the model sets every bit except bit 0 when the device is ready, so only bit 0 can steer the polling loop.

// File: rtl/fes_pkg.sv
package fes_pkg;
   localparam logic [7:0] OP_STATUS = 8'h05;
   localparam logic [7:0] OP_WREN   = 8'h06;
   localparam logic [7:0] OP_SMALL  = 8'h20;
   localparam logic [7:0] OP_LARGE  = 8'hD8;
   localparam logic [7:0] OP_WHOLE  = 8'hC7;
   localparam logic [7:0] FILLER    = 8'h00;

   typedef enum logic [2:0] {
      S_IDLE, S_CHECK, S_POLL_OP, S_POLL_RD, S_WREN, S_ERASE, S_NEXT, S_FIN
   } seq_state_t;
endpackage

// File: rtl/fes_req_check.sv
module fes_req_check #(
   parameter int AW         = 32,
   parameter int SMALL_UNIT = 4096,
   parameter bit SMALL_EN   = 1'b1
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] len,
   input  logic [AW-1:0] dev_size,
   input  logic [AW-1:0] sect_size,
   input  logic          small_req,
   output logic [AW-1:0] unit,
   output logic [7:0]    sect_op,
   output logic          bad_range,
   output logic          bad_align,
   output logic          whole
);
   import fes_pkg::*;

   initial begin
      assert ((SMALL_UNIT & (SMALL_UNIT - 1)) == 0 && SMALL_UNIT > 0)
         else $error("SMALL_UNIT must be a power of two");
   end

   logic          use_small;
   logic [AW:0]   range_end;

   generate
      if (SMALL_EN) begin : g_small
         assign use_small = small_req;
      end else begin : g_large_only
         assign use_small = 1'b0;
      end
   endgenerate

   assign unit      = use_small ? AW'(SMALL_UNIT) : sect_size;
   assign sect_op   = use_small ? OP_SMALL : OP_LARGE;
   assign range_end = {1'b0, addr} + {1'b0, len};
   assign bad_range = range_end > {1'b0, dev_size};
   assign bad_align = |(len & (unit - AW'(1)));
   assign whole     = (len == dev_size);
endmodule

// File: rtl/fes_poll_timer.sv
module fes_poll_timer #(
   parameter int TW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [TW-1:0] limit,
   output logic          expired
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (en && cnt != '1)   cnt <= cnt + TW'(1);
   end

   assign expired = (cnt >= limit);
endmodule

// File: rtl/fes_frame.sv
module fes_frame #(
   parameter int AW = 32
) (
   input  logic [7:0]    opcode,
   input  logic [AW-1:0] addr,
   input  logic          addr4,
   input  logic          chip,
   input  logic [2:0]    idx,
   output logic [7:0]    fbyte,
   output logic          flast
);
   localparam int NB = 4;

   initial begin
      assert (AW >= 24 && AW <= 32) else $error("AW must be 24..32");
   end

   logic [31:0] a32;
   logic [7:0]  ab [NB];
   logic [2:0]  nadr;
   logic [2:0]  sel;

   generate
      if (AW < 32) begin : g_pad
         assign a32 = {{(32-AW){1'b0}}, addr};
      end else begin : g_full
         assign a32 = addr;
      end
      for (genvar g = 0; g < NB; g++) begin : g_bytes
         assign ab[g] = a32[8*g +: 8];
      end
   endgenerate

   assign nadr  = chip ? 3'd0 : (addr4 ? 3'd4 : 3'd3);
   assign sel   = nadr - idx;
   assign fbyte = (idx == 3'd0) ? opcode : ab[sel[1:0]];
   assign flast = (idx == nadr);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
   parameter int AW         = 32,
   parameter int TW         = 32,
   parameter int SMALL_UNIT = 4096,
   parameter bit SMALL_EN   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   input  logic [AW-1:0] req_len,
   input  logic [AW-1:0] cfg_dev_size,
   input  logic [AW-1:0] cfg_sect_size,
   input  logic          cfg_small_erase,
   input  logic          cfg_addr4,
   input  logic [TW-1:0] cfg_poll_limit,
   output logic          busy,
   output logic          done,
   output logic          error,
   output logic          tx_valid,
   input  logic          tx_ready,
   output logic [7:0]    tx_byte,
   output logic          tx_last,
   input  logic          rx_valid,
   input  logic [7:0]    rx_byte
);
   import fes_pkg::*;

   seq_state_t    state;
   logic          wait_rx;
   logic [2:0]    idx;
   logic [AW-1:0] addr_q, len_q, unit_q;
   logic [7:0]    op_q;
   logic          chip_q, err_q;

   logic [AW-1:0] unit_c;
   logic [7:0]    sop_c;
   logic          bad_range, bad_align, whole;
   logic          expired;
   logic [7:0]    fr_byte;
   logic          fr_last;
   logic          take, answered;

   fes_req_check #(.AW(AW), .SMALL_UNIT(SMALL_UNIT), .SMALL_EN(SMALL_EN)) u_chk_req (
      .addr(addr_q), .len(len_q), .dev_size(cfg_dev_size), .sect_size(cfg_sect_size),
      .small_req(cfg_small_erase), .unit(unit_c), .sect_op(sop_c),
      .bad_range(bad_range), .bad_align(bad_align), .whole(whole)
   );

   fes_poll_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .clr(state == S_CHECK || state == S_NEXT),
      .en(state == S_POLL_OP || state == S_POLL_RD),
      .limit(cfg_poll_limit), .expired(expired)
   );

   fes_frame #(.AW(AW)) u_frame (
      .opcode(op_q), .addr(addr_q), .addr4(cfg_addr4), .chip(chip_q),
      .idx(idx), .fbyte(fr_byte), .flast(fr_last)
   );

   always_comb begin
      tx_valid = 1'b0;
      tx_byte  = FILLER;
      tx_last  = 1'b0;
      if (!wait_rx) begin
         unique case (state)
            S_POLL_OP: begin tx_valid = 1'b1; tx_byte = OP_STATUS; end
            S_POLL_RD: begin tx_valid = 1'b1; tx_byte = FILLER;  tx_last = 1'b1; end
            S_WREN:    begin tx_valid = 1'b1; tx_byte = OP_WREN; tx_last = 1'b1; end
            S_ERASE:   begin tx_valid = 1'b1; tx_byte = fr_byte; tx_last = fr_last; end
            default: ;
         endcase
      end
   end

   assign take     = tx_valid && tx_ready;
   assign answered = wait_rx && rx_valid;
   assign busy     = (state != S_IDLE);
   assign done     = (state == S_FIN);
   assign error    = done && err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         wait_rx <= 1'b0;
         idx     <= '0;
         addr_q  <= '0;
         len_q   <= '0;
         unit_q  <= '0;
         op_q    <= '0;
         chip_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (take) wait_rx <= 1'b1;
         else if (answered) wait_rx <= 1'b0;

         unique case (state)
            S_IDLE: if (req_valid) begin
               addr_q <= req_addr;
               len_q  <= req_len;
               err_q  <= 1'b0;
               state  <= S_CHECK;
            end
            S_CHECK: begin
               unit_q <= unit_c;
               chip_q <= whole;
               op_q   <= whole ? OP_WHOLE : sop_c;
               if (bad_range || bad_align) begin
                  err_q <= 1'b1;
                  state <= S_FIN;
               end else if (len_q == '0) begin
                  state <= S_FIN;
               end else begin
                  state <= S_POLL_OP;
               end
            end
            S_POLL_OP: if (answered) state <= S_POLL_RD;
            S_POLL_RD: if (answered) begin
               if (!rx_byte[0]) begin
                  state <= S_WREN;
               end else if (expired) begin
                  err_q <= 1'b1;
                  state <= S_FIN;
               end else begin
                  state <= S_POLL_OP;
               end
            end
            S_WREN: if (answered) begin
               idx   <= '0;
               state <= S_ERASE;
            end
            S_ERASE: if (answered) begin
               if (fr_last) state <= S_NEXT;
               else         idx   <= idx + 3'd1;
            end
            S_NEXT: begin
               addr_q <= addr_q + unit_q;
               len_q  <= len_q - unit_q;
               state  <= (chip_q || len_q == unit_q) ? S_FIN : S_POLL_OP;
            end
            S_FIN:   state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fes_checker.sv
module fes_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic       error,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_byte,
   input logic       tx_last,
   input logic       rx_valid
);
   logic       pend, first;
   logic [7:0] cur_op, prev_op;
   logic       prev_single;
   logic       take, is_erase;

   assign take     = tx_valid && tx_ready;
   assign is_erase = (tx_byte == 8'h20) || (tx_byte == 8'hD8) || (tx_byte == 8'hC7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend        <= 1'b0;
         first       <= 1'b1;
         cur_op      <= '0;
         prev_op     <= '0;
         prev_single <= 1'b0;
      end else begin
         if (take) pend <= 1'b1;
         else if (rx_valid) pend <= 1'b0;
         if (take) begin
            if (first) cur_op <= tx_byte;
            if (tx_last) begin
               first       <= 1'b1;
               prev_op     <= first ? tx_byte : cur_op;
               prev_single <= first;
            end else begin
               first <= 1'b0;
            end
         end
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_ERROR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done); // R10
   AST_BUSY_COVERS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy); // R10
   AST_IDLE_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tx_valid); // R11
   AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_last)); // R13
   AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> !tx_valid); // R13
   AST_WREN_PRECEDES_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      take && first && is_erase |-> prev_op == 8'h06 && prev_single); // R6
   AST_POLL_FILLER: assert property (@(posedge clk) disable iff (!rst_n)
      take && !first && cur_op == 8'h05 |-> tx_byte == 8'h00 && tx_last); // R5
endmodule

bind flash_erase_seq fes_checker u_fes_checker (.*);

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
   localparam int AW = 32;
   localparam int TW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0, req_len = '0;
   logic [AW-1:0] cfg_dev_size = 32'h10000, cfg_sect_size = 32'h4000;
   logic          cfg_small_erase = 1'b0, cfg_addr4 = 1'b0;
   logic [TW-1:0] cfg_poll_limit = 32'd100000;
   logic          busy, done, error, tx_valid, tx_last;
   logic          tx_ready = 1'b0, rx_valid = 1'b0;
   logic [7:0]    tx_byte, rx_byte = 8'h00;

   int checks = 0, errors = 0;
   logic [8:0] log_q[$];
   logic [8:0] exp_q[$];
   int  busy_left = 0, wip_per = 0;
   bit  stall_en = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   int  rx_wait = 0, tidx = 0;
   logic [7:0] topc = 8'h00;

   always #2 clk = ~clk;

   flash_erase_seq #(.AW(AW), .TW(TW)) dut (.*);

   // shifter model, active on the falling edge
   always @(negedge clk) begin
      if (rx_valid) rx_valid = 1'b0;
      if (rx_wait > 0) begin
         rx_wait = rx_wait - 1;
         if (rx_wait == 0) rx_valid = 1'b1;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
      if (tx_valid && tx_ready) begin
         log_q.push_back({tx_last, tx_byte});
         if (tidx == 0) topc = tx_byte;
         if (tidx == 1 && topc == 8'h05) begin
            if (busy_left > 0) begin rx_byte = 8'h01; busy_left = busy_left - 1; end
            else rx_byte = 8'hFE;
         end else begin
            rx_byte = 8'hA5;
         end
         if (tx_last && (topc == 8'h20 || topc == 8'hD8 || topc == 8'hC7))
            busy_left = wip_per;
         tidx = tx_last ? 0 : tidx + 1;
         rx_wait = 1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic push_polls(input int n);
      for (int i = 0; i <= n; i++) begin
         exp_q.push_back(9'h005);
         exp_q.push_back(9'h100);
      end
   endtask

   task automatic build_exp(input logic [31:0] a, input logic [31:0] l, input int wip0,
                            output bit exp_err);
      logic [32:0] unit;
      logic [31:0] cur;
      logic [7:0]  op;
      int          n;
      exp_q.delete();
      unit = cfg_small_erase ? 33'd4096 : {1'b0, cfg_sect_size};
      op   = cfg_small_erase ? 8'h20 : 8'hD8;
      exp_err = ({1'b0, a} + {1'b0, l} > {1'b0, cfg_dev_size}) || ((l % unit) != 0);
      if (exp_err || l == 0) return;
      if (l == cfg_dev_size) begin
         push_polls(wip0);
         exp_q.push_back(9'h106);
         exp_q.push_back(9'h1C7);
         return;
      end
      n = int'(l / unit);
      cur = a;
      for (int k = 0; k < n; k++) begin
         push_polls(k == 0 ? wip0 : wip_per);
         exp_q.push_back(9'h106);
         exp_q.push_back({1'b0, op});
         if (cfg_addr4) exp_q.push_back({1'b0, cur[31:24]});
         exp_q.push_back({1'b0, cur[23:16]});
         exp_q.push_back({1'b0, cur[15:8]});
         exp_q.push_back({1'b1, cur[7:0]});
         cur = cur + unit[31:0];
      end
   endtask

   // returns observed error; waits for done
   task automatic issue(input logic [31:0] a, input logic [31:0] l, input bit inject,
                        output bit got_err, output bit got_done);
      int n = 0;
      log_q.delete();
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_len = l;
      @(negedge clk);
      req_valid = 1'b0;
      check(busy == 1'b1, "R10", "busy after request", busy, 1);
      got_done = 1'b0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
         if (inject && n == 6 && busy && !done) begin
            req_valid = 1'b1; req_addr = 32'h0; req_len = cfg_dev_size;
         end else begin
            req_valid = 1'b0;
         end
      end
      req_valid = 1'b0;
      got_done = done;
      got_err  = error;
      @(negedge clk);
      check(!done && !busy, "R10", "done single cycle then idle", {done, busy}, 0);
   endtask

   task automatic run(input logic [31:0] a, input logic [31:0] l, input int wip0,
                      input bit inject, input string req);
      bit exp_err, got_err, got_done;
      busy_left = wip0;
      build_exp(a, l, wip0, exp_err);
      issue(a, l, inject, got_err, got_done);
      check(got_done && got_err == exp_err, req, "error flag at done", got_err, exp_err);
      if (log_q.size() != exp_q.size()) begin
         check(1'b0, req, "byte count", log_q.size(), exp_q.size());
      end else begin
         int bad = -1;
         for (int i = 0; i < exp_q.size(); i++)
            if (bad < 0 && log_q[i] != exp_q[i]) bad = i;
         if (bad >= 0) check(1'b0, req, "byte stream", log_q[bad], exp_q[bad]);
         else          check(1'b1, req, "byte stream", 0, 0);
      end
   endtask

   initial begin
      repeat (200000) @(negedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit te, td, bad06, shape;
      repeat (3) @(negedge clk);
      check(!busy && !done && !error && !tx_valid, "R10", "reset state",
            {busy, done, error, tx_valid}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R4 R5 R6 R7 R8: small granule, three address bytes, busy polls
      cfg_small_erase = 1'b1; cfg_addr4 = 1'b0; wip_per = 1;
      run(32'h3000, 32'h2000, 2, 1'b0, "R4 R7");
      // R4 R8: large sectors, four address bytes, stalls on tx_ready
      cfg_small_erase = 1'b0; cfg_addr4 = 1'b1; stall_en = 1'b1; wip_per = 0;
      run(32'h4000, 32'h8000, 1, 1'b0, "R4 R8");
      // R3: whole device
      run(32'h0, 32'h10000, 3, 1'b0, "R3");
      // R1: overflow past end, and exact fit at end
      run(32'hC000, 32'h8000, 0, 1'b0, "R1");
      run(32'hC000, 32'h4000, 0, 1'b0, "R1");
      // R2: misaligned length in both granule modes
      run(32'h0, 32'h2000, 0, 1'b0, "R2");
      cfg_small_erase = 1'b1;
      run(32'h0, 32'h1800, 0, 1'b0, "R2");
      // R12: zero length
      run(32'h1000, 32'h0, 0, 1'b0, "R12");
      // R11: second strobe while busy
      run(32'h2000, 32'h3000, 1, 1'b1, "R11");
      // R8: high address byte in both widths
      cfg_dev_size = 32'h0200_0000; cfg_addr4 = 1'b1;
      run(32'h0123_4000, 32'h1000, 0, 1'b0, "R8");
      cfg_addr4 = 1'b0;
      run(32'h0123_4000, 32'h1000, 0, 1'b0, "R8");
      cfg_dev_size = 32'h10000;

      // R9: device never ready
      cfg_poll_limit = 32'd20; busy_left = 1000000;
      issue(32'h0, 32'h1000, 1'b0, te, td);
      check(td && te, "R9", "timeout error", te, 1);
      bad06 = 1'b0; shape = (log_q.size() > 0);
      for (int i = 0; i < log_q.size(); i++) begin
         if (log_q[i][7:0] == 8'h06) bad06 = 1'b1;
         if (log_q[i] != ((i % 2 == 0) ? 9'h005 : 9'h100)) shape = 1'b0;
      end
      check(!bad06 && shape, "R9", "only status reads before abort", bad06, 0);
      cfg_poll_limit = 32'd100000;

      // R7 R8 R5: sweep of width, granule mode and sector count
      for (int a4 = 0; a4 < 2; a4++)
         for (int sm = 0; sm < 2; sm++)
            for (int n = 1; n <= 3; n++) begin
               logic [31:0] u;
               cfg_addr4 = a4[0]; cfg_small_erase = sm[0];
               stall_en = n[0]; wip_per = (n + 1) % 2;
               u = sm[0] ? 32'd4096 : cfg_sect_size;
               run(u, u * n, n % 3, 1'b0, "R7");
            end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule